// File: doc/BRIEF.md
# Debug Trigger Register Legalizer

This block owns the machine-mode register file of a small debug trigger unit with two hardware triggers. Software reaches it through a plain register port: an address, write data and a write enable, with read data returned combinationally for the address presented. The registers are a trigger selector, three per-trigger data words (control, compare value and a third word that is not implemented), and a read-only capability word.

Every control-word write passes through a legalizer before it is stored. Only two trigger kinds are accepted: the address/data match kind (code 2) and the extended match kind (code 6). For an accepted kind, unsupported fields are forced to zero, the debug-mode flag is dropped, and an access-size code that cannot be honoured falls back to "any size". The stored control and compare words of every trigger are driven out in parallel to a separate match unit.

Top module: `trig_csr_unit`

## Requirements
- R1: A write to the selector (address 0x7A0) updates it only when the written value is below the trigger count (2); otherwise the selection is kept. The selector reads back as its stored value.
- R2: A stored control word (address 0x7A1) always holds the accepted kind code in bits [31:28] and zero in the debug-mode bit 27.
- R3: A control write whose bits [31:28] are neither 2 nor 6 leaves the selected trigger's control word unchanged.
- R4: For kind 2, only bits 0 (load), 1 (store), 2 (execute), 3 (U), 4 (S), 6 (M) and the size field [17:16] keep their written values; every other bit reads as zero.
- R5: For kind 2, all four size codes in [17:16] are stored as written (0 any, 1 one byte, 2 two bytes, 3 four bytes).
- R6: For kind 6, the size field is [19:16]; codes 0, 1, 2, 3 and 5 are stored as written, and codes 4 and 6 to 15 are stored as 0.
- R7: For kind 6, bits 23 (VU) and 24 (VS) are kept in addition to the kind-2 enable bits 0 to 4 and 6; all other bits outside [19:16] read as zero.
- R8: Writes to the third data word (address 0x7A3) have no effect, and it always reads as zero.
- R9: The capability word (address 0x7A4) reads as 0x0000_0044 and ignores writes.
- R10: After reset the selector is 0, each control word is 0x2000_0000 and each compare word is 0.
- R11: A write to the compare word (address 0x7A2) stores all 32 bits unfiltered, whatever the trigger kind.
- R12: Control and compare reads and writes target only the trigger named by the selector, and each trigger's stored words appear on its slice of the parallel outputs (trigger i in bits [32*i+31:32*i]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, takes effect at the rising clock edge |
| reg_rdata | output | 32 | Read data for reg_addr, combinational; 0 for unmapped addresses |
| trig_ctrl | output | 64 | Stored control word of each trigger |
| trig_cmp | output | 64 | Stored compare word of each trigger |

## Verification
The assertions assume the write strobe and address are stable across each rising edge and never unknown once reset is released; the bench changes them only on falling edges and holds the strobe low after every single-cycle write. They also take the selector as the only source of trigger indexing, so the stimulus always programs the selector through the port before touching a trigger's words. Corner cases driven deliberately include out-of-range selector values, unsupported kind codes, every illegal extended size class, and stray bits in fields the kind does not support.

// File: rtl/trig_pkg.sv
// Package: shared widths, kind codes and register addresses of the trigger
// register block. Assumes a 32-bit register width.
package trig_pkg;
    localparam int XLEN = 32;
    localparam int AW   = 12;

    localparam logic [3:0] KIND_MATCH  = 4'd2;
    localparam logic [3:0] KIND_MATCHX = 4'd6;

    localparam logic [AW-1:0] A_SEL  = 12'h7A0;
    localparam logic [AW-1:0] A_CTRL = 12'h7A1;
    localparam logic [AW-1:0] A_CMP  = 12'h7A2;
    localparam logic [AW-1:0] A_AUX  = 12'h7A3;
    localparam logic [AW-1:0] A_CAPS = 12'h7A4;

    localparam logic [XLEN-1:0] CAPS_WORD = (XLEN'(1) << KIND_MATCH) |
                                            (XLEN'(1) << KIND_MATCHX);
    localparam logic [XLEN-1:0] CTRL_RESET = {KIND_MATCH, {(XLEN-4){1'b0}}};

    // True when an extended-kind size code can be honoured.
    function automatic logic size_code_ok(input logic [3:0] code);
        return (code <= 4'd3) || (code == 4'd5);
    endfunction
endpackage

// File: rtl/trig_ctrl_legalize.sv
// Module: combinational filter for control-word writes.
// Decides whether the written kind is accepted and builds the stored value
// with unsupported fields cleared. Assumes 32-bit words.
module trig_ctrl_legalize
    import trig_pkg::*;
(
    input  logic [XLEN-1:0] raw_i,
    output logic            accept_o,
    output logic [XLEN-1:0] clean_o
);
    localparam logic [XLEN-1:0] KEEP_BASE = 32'h0000_005F;
    localparam logic [XLEN-1:0] KEEP_VIRT = 32'h0180_0000;
    localparam logic [XLEN-1:0] SIZE2_MSK = 32'h0003_0000;
    localparam logic [XLEN-1:0] SIZE6_MSK = 32'h000F_0000;

    logic [3:0] kind;
    logic [3:0] size6;

    assign kind  = raw_i[XLEN-1 -: 4];
    assign size6 = raw_i[19:16];

    // Build the legal control value for the two accepted kinds.
    always_comb begin
        accept_o = 1'b0;
        clean_o  = '0;
        unique case (kind)
            KIND_MATCH: begin
                accept_o = 1'b1;
                clean_o  = {KIND_MATCH, {(XLEN-4){1'b0}}} |
                           (raw_i & (KEEP_BASE | SIZE2_MSK));
            end
            KIND_MATCHX: begin
                accept_o = 1'b1;
                clean_o  = {KIND_MATCHX, {(XLEN-4){1'b0}}} |
                           (raw_i & (KEEP_BASE | KEEP_VIRT));
                if (size_code_ok(size6))
                    clean_o = clean_o | (raw_i & SIZE6_MSK);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trig_slot.sv
// Module: storage for one trigger (control and compare words).
// Assumes the parent has already qualified the write strobes with the
// selector and the address, and that the control value is legalized.
module trig_slot
    import trig_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_req_i,
    input  logic            ctrl_ok_i,
    input  logic [XLEN-1:0] ctrl_val_i,
    input  logic            cmp_we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] ctrl_o,
    output logic [XLEN-1:0] cmp_o
);
    logic [XLEN-1:0] ctrl_q;
    logic [XLEN-1:0] cmp_q;

    // Control word: reset to the plain match kind, update on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (ctrl_req_i && ctrl_ok_i)
            ctrl_q <= ctrl_val_i;
    end

    // Compare word: stored unfiltered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_we_i)
            cmp_q <= wdata_i;
    end

    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_q;

    p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[31:28] == KIND_MATCH) || (ctrl_q[31:28] == KIND_MATCHX));
    p_dmode_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[27] == 1'b0);
    p_bad_kind_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_req_i && !ctrl_ok_i) |=> $stable(ctrl_q));
    p_size6_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[31:28] == KIND_MATCHX) |-> size_code_ok(ctrl_q[19:16]));
    p_size2_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[31:28] == KIND_MATCH) |-> (ctrl_q[24:18] == '0));
    p_cmp_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_i |=> (cmp_q == $past(wdata_i)));
endmodule

// File: rtl/trig_csr_unit.sv
// Module: top of the trigger register block. Decodes register accesses,
// keeps the trigger selector, instantiates one storage slot per trigger and
// muxes read data. Assumes single-cycle writes and combinational reads.
module trig_csr_unit
    import trig_pkg::*;
#(
    parameter int NTRIG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [11:0]           reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  reg_we,
    output logic [31:0]           reg_rdata,
    output logic [NTRIG*32-1:0]   trig_ctrl,
    output logic [NTRIG*32-1:0]   trig_cmp
);
    localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

    logic [SEL_W-1:0] sel_q;
    logic             ctrl_ok;
    logic [XLEN-1:0]  ctrl_clean;
    logic             wr_sel;
    logic             wr_ctrl;
    logic             wr_cmp;
    logic [XLEN-1:0]  ctrl_arr [NTRIG];
    logic [XLEN-1:0]  cmp_arr  [NTRIG];

    assign wr_sel  = reg_we && (reg_addr == A_SEL);
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_cmp  = reg_we && (reg_addr == A_CMP);

    // Selector: accept only in-range trigger numbers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_sel && (reg_wdata < XLEN'(NTRIG)))
            sel_q <= reg_wdata[SEL_W-1:0];
    end

    trig_ctrl_legalize u_legal (
        .raw_i    (reg_wdata),
        .accept_o (ctrl_ok),
        .clean_o  (ctrl_clean)
    );

    for (genvar g = 0; g < NTRIG; g++) begin : g_slot
        trig_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_req_i (wr_ctrl && (sel_q == SEL_W'(g))),
            .ctrl_ok_i  (ctrl_ok),
            .ctrl_val_i (ctrl_clean),
            .cmp_we_i   (wr_cmp && (sel_q == SEL_W'(g))),
            .wdata_i    (reg_wdata),
            .ctrl_o     (ctrl_arr[g]),
            .cmp_o      (cmp_arr[g])
        );
        assign trig_ctrl[g*32 +: 32] = ctrl_arr[g];
        assign trig_cmp[g*32 +: 32]  = cmp_arr[g];
    end

    // Read mux: selected trigger for per-trigger words, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_SEL:   reg_rdata = XLEN'(sel_q);
            A_CTRL:  reg_rdata = ctrl_arr[sel_q];
            A_CMP:   reg_rdata = cmp_arr[sel_q];
            A_AUX:   reg_rdata = '0;
            A_CAPS:  reg_rdata = CAPS_WORD;
            default: reg_rdata = '0;
        endcase
    end

    p_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_q) < NTRIG);
    p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (reg_wdata >= XLEN'(NTRIG))) |=> $stable(sel_q));
    p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (reg_wdata < XLEN'(NTRIG))) |=> (32'(sel_q) == $past(reg_wdata)));
    p_aux_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_AUX) |-> (reg_rdata == '0));
    p_caps_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CAPS) |-> (reg_rdata == 32'h44));
endmodule

// File: tb/trig_csr_unit_tb_top.sv
`timescale 1ns/1ps
module trig_csr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [63:0] trig_ctrl;
    logic [63:0] trig_cmp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_csr_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .trig_ctrl (trig_ctrl),
        .trig_cmp  (trig_cmp)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h7A0, 32'h1,         12'h7A0, 32'h1,         8'd1},  // R1 in range
        '{1'b1, 12'h7A0, 32'h2,         12'h7A0, 32'h1,         8'd1},  // R1 out of range kept
        '{1'b1, 12'h7A0, 32'hFFFF_FFFF, 12'h7A0, 32'h1,         8'd1},  // R1 large value kept
        '{1'b1, 12'h7A0, 32'h0,         12'h7A0, 32'h0,         8'd1},  // R1 back to 0
        '{1'b1, 12'h7A1, 32'hFFFF_FFFF, 12'h7A1, 32'h2000_0000, 8'd3},  // R3 kind 15
        '{1'b1, 12'h7A1, 32'h3000_005F, 12'h7A1, 32'h2000_0000, 8'd3},  // R3 kind 3
        '{1'b1, 12'h7A1, 32'h2FFF_FFFF, 12'h7A1, 32'h2003_005F, 8'd4},  // R4 and R2
        '{1'b1, 12'h7A1, 32'h2188_0004, 12'h7A1, 32'h2000_0004, 8'd4},  // R4 stray bits
        '{1'b1, 12'h7A1, 32'h2002_0003, 12'h7A1, 32'h2002_0003, 8'd5},  // R5 size 2
        '{1'b1, 12'h7A1, 32'h6FFF_FFFF, 12'h7A1, 32'h6180_005F, 8'd7},  // R7 and R6 code 15
        '{1'b1, 12'h7A1, 32'h6005_0001, 12'h7A1, 32'h6005_0001, 8'd6},  // R6 code 5
        '{1'b1, 12'h7A1, 32'h6004_0001, 12'h7A1, 32'h6000_0001, 8'd6},  // R6 code 4
        '{1'b1, 12'h7A2, 32'hDEAD_BEEF, 12'h7A2, 32'hDEAD_BEEF, 8'd11}, // R11 kind 6
        '{1'b1, 12'h7A1, 32'h2003_0048, 12'h7A1, 32'h2003_0048, 8'd5},  // R5 size 3
        '{1'b1, 12'h7A3, 32'h1234_5678, 12'h7A3, 32'h0,         8'd8},  // R8
        '{1'b1, 12'h7A4, 32'h0,         12'h7A4, 32'h44,        8'd9},  // R9
        '{1'b1, 12'h7A0, 32'h1,         12'h7A1, 32'h2000_0000, 8'd12}, // R12 other slot
        '{1'b1, 12'h7A2, 32'h0000_0001, 12'h7A2, 32'h0000_0001, 8'd11}  // R11 kind 2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        rd(12'h7A0, v); check("R10 selector", v, 32'h0);
        rd(12'h7A1, v); check("R10 control", v, 32'h2000_0000);
        rd(12'h7A2, v); check("R10 compare", v, 32'h0);
        check("R10 outputs ctrl", trig_ctrl, 64'h2000_0000_2000_0000);
        check("R10 outputs cmp0", trig_cmp[31:0], 32'h0);
        check("R10 outputs cmp1", trig_cmp[63:32], 32'h0);
        rd(12'h7A4, v); check("R9 caps after reset", v, 32'h44);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
            rd(VECS[i].raddr, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R12 parallel outputs reflect each slot independently
        check("R12 slot0 ctrl", trig_ctrl[31:0], 32'h2003_0048);
        check("R12 slot1 ctrl", trig_ctrl[63:32], 32'h2000_0000);
        check("R12 slot0 cmp", trig_cmp[31:0], 32'hDEAD_BEEF);
        check("R12 slot1 cmp", trig_cmp[63:32], 32'h1);
        wr(12'h7A0, 32'h0);
        rd(12'h7A2, v); check("R12 reselect slot0 cmp", v, 32'hDEAD_BEEF);
        // R3 bad kind leaves slot 0 untouched
        wr(12'h7A1, 32'h0000_00FF);
        rd(12'h7A1, v); check("R3 kind 0 ignored", v, 32'h2003_0048);
        // R2 debug-mode bit dropped on kind 6
        wr(12'h7A1, 32'h6800_0003);
        rd(12'h7A1, v); check("R2 dmode cleared", v, 32'h6000_0003);
        // R6 every illegal extended size class falls back to 0
        for (int c = 0; c < 16; c++) begin
            logic [31:0] e;
            e = ((c <= 3) || (c == 5)) ? (32'h6000_0001 | (32'(c) << 16)) : 32'h6000_0001;
            wr(12'h7A1, 32'h6000_0001 | (32'(c) << 16));
            rd(12'h7A1, v); check($sformatf("R6 size code %0d", c), v, e);
        end
        // R8 aux write leaves control and compare intact
        wr(12'h7A3, 32'hFFFF_FFFF);
        rd(12'h7A2, v); check("R8 compare intact", v, 32'hDEAD_BEEF);
        // R10 reset again restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h7A1, v); check("R10 control after re-reset", v, 32'h2000_0000);
        check("R10 cmp after re-reset", trig_cmp[31:0], 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule